// File: doc/BRIEF.md
# Blink Timing Generator

This block produces the blink phase for a character display and gates each character with it. It counts vertical fields, one strobe per field, over a repeating period of either 64 fields (long, about one second) or 32 fields (short, about half a second). Within each period the first part is the visible phase and the remainder is the hidden phase. The duty setting chooses whether the visible part is a quarter, a half or three quarters of the period.

Every character carries a blink attribute bit. The block compares the attribute with the current phase and decides whether the character is drawn. A character whose attribute is clear is always drawn. Several character lanes are gated in parallel. The blink phase is also brought out as a waveform.

The phase is held by a three-state machine:
- `ST_OFF` means blinking is inactive.
- `ST_SHOW` is the visible phase.
- `ST_HIDE` is the hidden phase.

Its transitions are:
- HALT: any state goes to `ST_OFF` when the global enable is low or the duty code is 00.
- RESUME: `ST_OFF` goes to the phase that matches the field count.
- FADE: `ST_SHOW` goes to `ST_HIDE` when the count reaches the visible length.
- WRAP: `ST_HIDE` goes to `ST_SHOW` when the count returns to zero, either at the end of a period or on a period restart.

Top module: `blink_timer`

## Requirements
- R1: Reset is asynchronous and active low. It clears the field counter to zero and puts the machine in `ST_OFF`. While in reset and after it, `blink_wave` is 0 and every `char_show` bit is 1 until a hidden phase is reached.
- R2: A lane whose `char_blink` bit is 0 has `char_show` = 1 in every cycle. A lane whose bit is 1 has `char_show` equal to the inverse of `blink_wave`, combinationally in the same cycle.
- R3: When `blink_en` is sampled low at a clock edge, `blink_wave` is 0 from that edge onward and all lanes are shown. The field counter keeps counting, and the phase resumes from the count once `blink_en` is high again.
- R4: Duty code `blink_sel[1:0]` = 00 disables blinking in the same way as R3.
- R5: `blink_sel[2]` = 0 selects the long period of 64 fields. The counter runs 0..63 and then returns to 0.
- R6: `blink_sel[2]` = 1 selects the short period of 32 fields. The counter runs 0..31 and then returns to 0.
- R7: A change of `blink_sel[2]`, seen against its value at the previous edge, forces the counter to 0 at that edge. This takes priority over a coincident field strobe.
- R8: Duty codes 01, 10 and 11 make characters visible for count values below P/4, P/2 and 3P/4 respectively, where P is the period. `blink_wave` is 1 at all other count values.
- R9: The counter advances by one only at an edge where `field_pulse` is 1. Otherwise it holds. `blink_wave` follows the counter value registered at the same edge, using the settings sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low clear |
| field_pulse | input | 1 | One-cycle strobe per vertical field |
| blink_sel | input | 3 | Bit 2 selects the short period. Bits 1:0 are the duty code. |
| blink_en | input | 1 | Global blink enable |
| char_blink | input | LANES | Blink attribute bit of each character lane |
| char_show | output | LANES | Per-lane display enable (1 = draw the character) |
| blink_wave | output | 1 | 1 during the hidden phase of an active blink |

## Verification
The hardest case to reach is a period restart that lands exactly on a field strobe, in the middle of a hidden phase. Here the restart must win over the increment, and the phase must jump straight back to visible. The stimulus runs into the hidden part of a long period first. It then flips the period bit in the same cycle as a strobe, and repeats this in both directions and with gaps between strobes as short as one cycle. Irregular strobe spacing, disable windows placed inside hidden phases, and a reset asserted during a hidden phase cover the remaining boundaries.

// File: rtl/blink_pkg.sv
package blink_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_SHOW = 2'd1,
        ST_HIDE = 2'd2
    } blink_state_t;

    // Number of visible fields in a period for a given duty code.
    function automatic int unsigned visible_len(int unsigned period, logic [1:0] duty);
        return (period * int'(duty)) / 4;
    endfunction

endpackage

// File: rtl/blink_field_counter.sv
module blink_field_counter #(
    parameter int unsigned LONG_FIELDS  = 64,
    parameter int unsigned SHORT_FIELDS = 32,
    parameter int unsigned CNT_W        = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             field_pulse_i,
    input  logic             short_sel_i,
    output logic [CNT_W-1:0] cnt_q_o,
    output logic [CNT_W-1:0] cnt_next_o
);

    localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(LONG_FIELDS - 1);
    localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(SHORT_FIELDS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_n;
    logic [CNT_W-1:0] last_val;
    logic             prev_short_q;
    logic             restart;

    always_comb begin
        last_val = short_sel_i ? LAST_SHORT : LAST_LONG;
        restart  = (short_sel_i != prev_short_q);
        if (restart) begin
            cnt_n = '0;
        end else if (field_pulse_i) begin
            cnt_n = (cnt_q >= last_val) ? '0 : cnt_q + 1'b1;
        end else begin
            cnt_n = cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q        <= '0;
            prev_short_q <= 1'b0;
        end else begin
            cnt_q        <= cnt_n;
            prev_short_q <= short_sel_i;
        end
    end

    assign cnt_q_o    = cnt_q;
    assign cnt_next_o = cnt_n;

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_LONG); // R5
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!field_pulse_i && !restart) |=> $stable(cnt_q)); // R9
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (field_pulse_i && !restart && cnt_q < last_val) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R9
    AST_PERIOD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0)); // R7

endmodule

// File: rtl/blink_phase_fsm.sv
module blink_phase_fsm
    import blink_pkg::*;
#(
    parameter int unsigned LONG_FIELDS  = 64,
    parameter int unsigned SHORT_FIELDS = 32,
    parameter int unsigned CNT_W        = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_q_i,
    input  logic [CNT_W-1:0] cnt_next_i,
    input  logic             short_sel_i,
    input  logic [1:0]       duty_i,
    input  logic             blink_en_i,
    output logic             hide_o
);

    blink_state_t state_q;
    blink_state_t state_n;
    logic [CNT_W:0] vis_len;
    logic           past_vis;
    logic           active;

    always_comb begin
        vis_len  = (CNT_W+1)'(visible_len(short_sel_i ? SHORT_FIELDS : LONG_FIELDS, duty_i));
        past_vis = ({1'b0, cnt_next_i} >= vis_len);
        active   = blink_en_i && (duty_i != 2'b00);
    end

    // Next-state logic
    always_comb begin
        state_n = state_q;
        if (!active) begin
            state_n = ST_OFF;                                 // HALT
        end else begin
            unique case (state_q)
                ST_OFF:  state_n = past_vis ? ST_HIDE : ST_SHOW; // RESUME
                ST_SHOW: state_n = past_vis ? ST_HIDE : ST_SHOW; // FADE
                ST_HIDE: state_n = past_vis ? ST_HIDE : ST_SHOW; // WRAP
                default: state_n = ST_OFF;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_n;
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_HIDE: hide_o = 1'b1;
            default: hide_o = 1'b0;
        endcase
    end

    AST_OFF_NO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !blink_en_i |=> (state_q == ST_OFF)); // R3
    AST_OFF_DUTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_i == 2'b00) |=> (state_q == ST_OFF)); // R4
    AST_WRAP_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q_i == '0 && state_q != ST_OFF) |-> (state_q == ST_SHOW)); // R8
    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF || state_q == ST_SHOW || state_q == ST_HIDE)); // R9

endmodule

// File: rtl/blink_char_gate.sv
module blink_char_gate #(
    parameter int unsigned LANES = 4
) (
    input  logic             hide_i,
    input  logic [LANES-1:0] char_blink_i,
    output logic [LANES-1:0] char_show_o
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign char_show_o[g] = !(char_blink_i[g] && hide_i);
    end

endmodule

// File: rtl/blink_timer.sv
module blink_timer
    import blink_pkg::*;
#(
    parameter int unsigned LONG_FIELDS  = 64,
    parameter int unsigned SHORT_FIELDS = 32,
    parameter int unsigned LANES        = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             field_pulse,
    input  logic [2:0]       blink_sel,
    input  logic             blink_en,
    input  logic [LANES-1:0] char_blink,
    output logic [LANES-1:0] char_show,
    output logic             blink_wave
);

    localparam int unsigned CNT_W = $clog2(LONG_FIELDS);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_next;
    logic             hide;

    blink_field_counter #(
        .LONG_FIELDS (LONG_FIELDS),
        .SHORT_FIELDS(SHORT_FIELDS),
        .CNT_W       (CNT_W)
    ) u_counter (
        .clk          (clk),
        .rst_n        (rst_n),
        .field_pulse_i(field_pulse),
        .short_sel_i  (blink_sel[2]),
        .cnt_q_o      (cnt_q),
        .cnt_next_o   (cnt_next)
    );

    blink_phase_fsm #(
        .LONG_FIELDS (LONG_FIELDS),
        .SHORT_FIELDS(SHORT_FIELDS),
        .CNT_W       (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_q_i    (cnt_q),
        .cnt_next_i (cnt_next),
        .short_sel_i(blink_sel[2]),
        .duty_i     (blink_sel[1:0]),
        .blink_en_i (blink_en),
        .hide_o     (hide)
    );

    blink_char_gate #(
        .LANES(LANES)
    ) u_gate (
        .hide_i      (hide),
        .char_blink_i(char_blink),
        .char_show_o (char_show)
    );

    assign blink_wave = hide;

    AST_SHORT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(blink_sel[2]) && blink_sel[2]) |-> (cnt_q < CNT_W'(SHORT_FIELDS))); // R6
    AST_WAVE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !blink_wave); // R1

endmodule

// File: tb/blink_timer_tb.sv
module blink_timer_tb;

    localparam int LANES = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             field_pulse = 1'b0;
    logic [2:0]       blink_sel = 3'b010;
    logic             blink_en = 1'b1;
    logic [LANES-1:0] char_blink = '1;
    logic [LANES-1:0] char_show;
    logic             blink_wave;

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    done     = 0;
    string cur_req  = "R1";
    bit    rand_chars = 0;

    // behavioural reference state
    int m_cnt  = 0;
    int m_prev = 0;
    bit m_hid  = 0;

    always #2.5ns clk = ~clk;

    blink_timer #(.LANES(LANES)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .field_pulse(field_pulse),
        .blink_sel  (blink_sel),
        .blink_en   (blink_en),
        .char_blink (char_blink),
        .char_show  (char_show),
        .blink_wave (blink_wave)
    );

    // reference model, updated on every edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_prev = 0; m_hid = 0;
        end else begin
            int per, nxt, vis;
            per = blink_sel[2] ? 32 : 64;
            if (int'(blink_sel[2]) != m_prev) nxt = 0;
            else if (field_pulse) nxt = (m_cnt + 1) % per;
            else nxt = m_cnt;
            m_prev = int'(blink_sel[2]);
            m_cnt  = nxt;
            vis    = per * int'(blink_sel[1:0]) / 4;
            m_hid  = blink_en && (blink_sel[1:0] != 2'b00) && (nxt >= vis);
        end
    end

    // compare away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            logic [LANES-1:0] exp_show;
            for (int i = 0; i < LANES; i++) exp_show[i] = !(char_blink[i] && m_hid);
            n_checks++;
            if (blink_wave !== m_hid || char_show !== exp_show) begin
                n_fails++;
                $display("FAIL %s: wave=%0b show=%b expected wave=%0b show=%b (t=%0t)",
                         cur_req, blink_wave, char_show, m_hid, exp_show, $time);
            end
        end
    end

    task automatic step(input bit fp);
        @(posedge clk);
        #1ns;
        field_pulse = fp;
        if (rand_chars) char_blink = LANES'($urandom);
    endtask

    task automatic fields(input int n, input int gap);
        for (int f = 0; f < n; f++) begin
            step(1'b1);
            for (int k = 1; k < gap; k++) step(1'b0);
        end
    endtask

    initial begin
        // R1: reset state
        cur_req = "R1";
        repeat (4) step(1'b1);
        @(posedge clk); #1ns; rst_n = 1'b1;
        // R5: long period, 50% duty, two full periods
        cur_req = "R5";
        blink_sel = 3'b010; char_blink = 4'b1011;
        fields(130, 3);
        // R8: 25% and 75% visible in long period
        cur_req = "R8";
        blink_sel = 3'b001; fields(66, 2);
        blink_sel = 3'b011; fields(66, 2);
        // R6: short period with all three duties
        cur_req = "R6";
        blink_sel = 3'b101; fields(34, 2);
        blink_sel = 3'b110; fields(34, 2);
        blink_sel = 3'b111; fields(34, 2);
        // R7: period flips, some coincident with a strobe, inside hidden phases
        cur_req = "R7";
        for (int r = 0; r < 4; r++) begin
            blink_sel = 3'b001; fields(40, 1);
            blink_sel = 3'b101; step(1'b1);
            fields(28, 2);
            blink_sel = 3'b001; step(1'b0);
            fields(10, 1);
        end
        // R2: random attributes every cycle
        cur_req = "R2";
        rand_chars = 1; blink_sel = 3'b010;
        fields(80, 2);
        char_blink = '0; rand_chars = 0;
        fields(70, 2);
        // R3: enable dropped inside hidden phases
        cur_req = "R3";
        char_blink = '1; blink_sel = 3'b001;
        for (int r = 0; r < 3; r++) begin
            blink_en = 1'b1; fields(30, 2);
            blink_en = 1'b0; fields(25, 2);
        end
        blink_en = 1'b1; fields(20, 2);
        // R4: duty code 00 in both periods
        cur_req = "R4";
        blink_sel = 3'b000; fields(70, 2);
        blink_sel = 3'b100; fields(40, 2);
        blink_sel = 3'b001; fields(30, 2);
        // R9: irregular strobes, back to back and with gaps
        cur_req = "R9";
        blink_sel = 3'b110;
        for (int s = 0; s < 600; s++) step(($urandom % 3) == 0);
        fields(40, 1);
        // R1: clear in the middle of a hidden phase
        cur_req = "R1";
        blink_sel = 3'b001; fields(40, 2);
        @(posedge clk); #1ns; rst_n = 1'b0;
        repeat (3) step(1'b1);
        @(posedge clk); #1ns; rst_n = 1'b1;
        fields(70, 2);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fails++;
            $display("FAIL watchdog %s: actual=running expected=finished", cur_req);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

endmodule